// File: doc/BRIEF.md
# One-Time-Programmable Memory Burn Sequencer

This block writes a byte image into a one-time-programmable memory and confirms the result. After a start pulse, it walks the addresses from zero up to a last address that is given at start. For each address it fetches the intended byte from an image source. It then applies fixed-length program pulses with the high-voltage enable raised, and reads the cell back after every pulse. A byte that still differs after the allowed number of pulses stops the run with a failure. That failure records the address.

When every byte has verified, the high-voltage enable drops and the sequencer makes a second pass over the array at the normal supply level. It fetches each image byte again and compares it with a fresh read. A single mismatch ends the run as failed. If every byte matches, the run ends as passed. The pass and fail flags hold their value until the next start. A failure also leaves the offending address on a diagnostic output.

The memory port is abstract. It has an address, write data, a registered read-data return that arrives one clock after the read strobe, a register/memory select and a read/write select. It also carries a program-pulse strobe and the high-voltage enable.

Top module: `otp_burn_seq`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `pass_o`, `fail_o`, `hv_en_o` and `mem_pulse_o` are all low.
- R2: A `start_i` pulse while idle latches `last_addr_i` and begins at address 0. In the next cycle `busy_o` is high and both `pass_o` and `fail_o` are low. A `start_i` pulse while `busy_o` is high has no effect: the run's pulse, fetch and read counts and its result are unchanged.
- R3: Each program attempt holds `mem_pulse_o` high for exactly PULSE_CLKS consecutive clocks. Throughout that time the mode is write (`mem_rw_o`=0), the memory array is selected (`mem_regsel_o`=0) and `hv_en_o`=1.
- R4: The cycle after every pulse presents one read strobe (`mem_rd_o`=1, `mem_rw_o`=1) with `hv_en_o` still high. The byte returned on `mem_rdata_i` one clock later is compared with the image byte. There is exactly one such read per pulse.
- R5: A verify match advances to the next address and clears the attempt count, so every address gets its full budget of MAX_TRIES pulses.
- R6: A verify mismatch triggers another pulse at the same address. A mismatch on the MAX_TRIES-th attempt ends the run with `fail_o`=1 and `fail_addr_o` set to that address. A match on that last attempt still advances.
- R7: After the last address verifies, `hv_en_o` falls and every address from 0 to the last one is read once more with `hv_en_o`=0. The first mismatch ends the run with `fail_o`=1 and `fail_addr_o` set to that address. If all bytes match, the run ends with `pass_o`=1.
- R8: `pass_o` and `fail_o` are never high together, are never high while busy, and stay unchanged from the end of a run until the next accepted start.
- R9: Each image byte is requested by holding `img_req_o` high with `img_addr_o` stable until `img_vld_i` returns the data. There is one request per address in the programming pass and one per address read in the compare pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, used only while idle |
| last_addr_i | input | ADDR_W | Last address to burn, latched at start |
| img_req_o | output | 1 | Image byte request |
| img_addr_o | output | ADDR_W | Address of requested image byte |
| img_data_i | input | DATA_W | Image byte |
| img_vld_i | input | 1 | Image byte valid, one cycle |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Data to program |
| mem_rdata_i | input | DATA_W | Read data, valid one clock after the read strobe |
| mem_regsel_o | output | 1 | Register/memory select, 0 = memory array |
| mem_rw_o | output | 1 | 1 = read or verify, 0 = program |
| mem_rd_o | output | 1 | Read strobe |
| mem_pulse_o | output | 1 | Program pulse strobe |
| hv_en_o | output | 1 | Programming high-voltage enable |
| busy_o | output | 1 | Run in progress |
| pass_o | output | 1 | Sticky device-passed flag |
| fail_o | output | 1 | Sticky device-failed flag |
| fail_addr_o | output | ADDR_W | Address of the failing byte |

## Verification
Two events can land in the same cycle. The first is the verify read that uses the last allowed attempt: it is both a limit hit and a possible match. The bench provokes this with a byte that needs exactly MAX_TRIES pulses and expects a pass, and with a byte that needs one pulse more and expects a failure after exactly MAX_TRIES pulses. The second is a start pulse that arrives while a run is active. The bench injects one mid-run and judges it by the run's counted pulses, fetches and compare reads, which must equal the values for an undisturbed run.

// File: rtl/otp_pkg.sv
package otp_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_PULSE,
      S_VRD,
      S_VCMP,
      S_CRD,
      S_CCMP
   } otp_state_e;
endpackage

// File: rtl/otp_pulse_timer.sv
// Measures one program pulse: last_o marks the final cycle of PULSE_CLKS.
module otp_pulse_timer #(
   parameter int PULSE_CLKS = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic last_o
);
   if (PULSE_CLKS < 1) begin : g_bad_len
      $error("PULSE_CLKS must be at least 1");
   end

   if (PULSE_CLKS == 1) begin : g_single
      assign last_o = run_i;
   end else begin : g_count
      localparam int CW = $clog2(PULSE_CLKS);
      localparam logic [CW-1:0] LAST = CW'(PULSE_CLKS - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt_q <= '0;
         else if (!run_i) cnt_q <= '0;
         else             cnt_q <= cnt_q + 1'b1;
      end

      assign last_o = run_i && (cnt_q == LAST);
   end
endmodule

// File: rtl/otp_try_ctr.sv
// Counts failed verifies of one byte; limit_o flags that the current
// mismatch is the last one allowed.
module otp_try_ctr #(
   parameter int MAX_TRIES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic limit_o
);
   if (MAX_TRIES < 1) begin : g_bad_tries
      $error("MAX_TRIES must be at least 1");
   end

   if (MAX_TRIES == 1) begin : g_one
      assign limit_o = 1'b1;
   end else begin : g_cnt
      localparam int TW = $clog2(MAX_TRIES + 1);
      localparam logic [TW-1:0] LIM = TW'(MAX_TRIES - 1);
      logic [TW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt_q <= '0;
         else if (clr_i) cnt_q <= '0;
         else if (inc_i) cnt_q <= cnt_q + 1'b1;
      end

      assign limit_o = (cnt_q == LIM);
   end
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
   import otp_pkg::*;
#(
   parameter int ADDR_W     = 14,
   parameter int DATA_W     = 8,
   parameter int PULSE_CLKS = 50000,
   parameter int MAX_TRIES  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] last_addr_i,
   output logic              img_req_o,
   output logic [ADDR_W-1:0] img_addr_o,
   input  logic [DATA_W-1:0] img_data_i,
   input  logic              img_vld_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              mem_regsel_o,
   output logic              mem_rw_o,
   output logic              mem_rd_o,
   output logic              mem_pulse_o,
   output logic              hv_en_o,
   output logic              busy_o,
   output logic              pass_o,
   output logic              fail_o,
   output logic [ADDR_W-1:0] fail_addr_o
);
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ADDR_W and DATA_W must be positive");
   end

   otp_state_e        state_q;
   logic [ADDR_W-1:0] addr_q, last_q, fail_addr_q;
   logic [DATA_W-1:0] data_q;
   logic              final_q, pass_q, fail_q;
   logic              pulse_last, try_limit, match, at_last;

   otp_pulse_timer #(.PULSE_CLKS(PULSE_CLKS)) u_ptimer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state_q == S_PULSE),
      .last_o (pulse_last)
   );

   otp_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_tries (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (state_q == S_FETCH),
      .inc_i   ((state_q == S_VCMP) && !match),
      .limit_o (try_limit)
   );

   assign match   = (mem_rdata_i == data_q);
   assign at_last = (addr_q == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         addr_q      <= '0;
         last_q      <= '0;
         data_q      <= '0;
         final_q     <= 1'b0;
         pass_q      <= 1'b0;
         fail_q      <= 1'b0;
         fail_addr_q <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: if (start_i) begin
               state_q     <= S_FETCH;
               addr_q      <= '0;
               last_q      <= last_addr_i;
               final_q     <= 1'b0;
               pass_q      <= 1'b0;
               fail_q      <= 1'b0;
               fail_addr_q <= '0;
            end
            S_FETCH: if (img_vld_i) begin
               data_q  <= img_data_i;
               state_q <= final_q ? S_CRD : S_PULSE;
            end
            S_PULSE: if (pulse_last) state_q <= S_VRD;
            S_VRD:   state_q <= S_VCMP;
            S_VCMP: begin
               if (match) begin
                  state_q <= S_FETCH;
                  if (at_last) begin
                     final_q <= 1'b1;
                     addr_q  <= '0;
                  end else begin
                     addr_q  <= addr_q + 1'b1;
                  end
               end else if (try_limit) begin
                  fail_q      <= 1'b1;
                  fail_addr_q <= addr_q;
                  state_q     <= S_IDLE;
               end else begin
                  state_q <= S_PULSE;
               end
            end
            S_CRD:   state_q <= S_CCMP;
            S_CCMP: begin
               if (!match) begin
                  fail_q      <= 1'b1;
                  fail_addr_q <= addr_q;
                  state_q     <= S_IDLE;
               end else if (at_last) begin
                  pass_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  addr_q  <= addr_q + 1'b1;
                  state_q <= S_FETCH;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy_o       = (state_q != S_IDLE);
   assign img_req_o    = (state_q == S_FETCH);
   assign img_addr_o   = addr_q;
   assign mem_addr_o   = addr_q;
   assign mem_wdata_o  = data_q;
   assign mem_regsel_o = 1'b0;
   assign mem_rw_o     = (state_q != S_PULSE);
   assign mem_rd_o     = (state_q == S_VRD) || (state_q == S_CRD);
   assign mem_pulse_o  = (state_q == S_PULSE);
   assign hv_en_o      = busy_o && !final_q;
   assign pass_o       = pass_q;
   assign fail_o       = fail_q;
   assign fail_addr_o  = fail_addr_q;
endmodule

// File: rtl/otp_burn_seq_chk.sv
module otp_burn_seq_chk #(
   parameter int ADDR_W     = 14,
   parameter int PULSE_CLKS = 50000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              img_req_o,
   input logic              img_vld_i,
   input logic [ADDR_W-1:0] img_addr_o,
   input logic              mem_regsel_o,
   input logic              mem_rw_o,
   input logic              mem_rd_o,
   input logic              mem_pulse_o,
   input logic              hv_en_o,
   input logic              busy_o,
   input logic              pass_o,
   input logic              fail_o
);
   logic [31:0] pw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pw_q <= '0;
      else if (mem_pulse_o) pw_q <= pw_q + 1'b1;
      else                  pw_q <= '0;
   end

   p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass_o && fail_o));
   p_flags_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_o || fail_o) |-> !busy_o);
   p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (!pass_o && !fail_o));
   p_pulse_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_pulse_o |-> (hv_en_o && !mem_rw_o && !mem_regsel_o));
   p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_pulse_o) |-> (pw_q == 32'(PULSE_CLKS)));
   p_read_after_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_pulse_o) |-> (mem_rd_o && mem_rw_o && hv_en_o));
   p_hv_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hv_en_o |-> busy_o);
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (img_req_o && !img_vld_i) |=> (img_req_o && $stable(img_addr_o)));
endmodule

bind otp_burn_seq otp_burn_seq_chk #(.ADDR_W(ADDR_W), .PULSE_CLKS(PULSE_CLKS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .img_req_o    (img_req_o),
   .img_vld_i    (img_vld_i),
   .img_addr_o   (img_addr_o),
   .mem_regsel_o (mem_regsel_o),
   .mem_rw_o     (mem_rw_o),
   .mem_rd_o     (mem_rd_o),
   .mem_pulse_o  (mem_pulse_o),
   .hv_en_o      (hv_en_o),
   .busy_o       (busy_o),
   .pass_o       (pass_o),
   .fail_o       (fail_o)
);

// File: tb/otp_burn_seq_bench.sv
`timescale 1ns/1ps
module otp_burn_seq_bench;
   localparam int AW = 6;
   localparam int DW = 8;
   localparam int PC = 4;
   localparam int MT = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] last_addr = '0;
   logic          img_req;
   logic [AW-1:0] img_addr;
   logic [DW-1:0] img_data = '0;
   logic          img_vld = 1'b0;
   logic          img_lat = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_regsel, mem_rw, mem_rd, mem_pulse, hv, busy, pass, fail;
   logic [AW-1:0] fail_addr;

   int n_tests = 0;
   int n_fail  = 0;

   logic [7:0] img  [64];
   logic [7:0] mem  [64];
   int         need [64];
   int         hits [64];
   int         bad_addr = -1;
   logic       wipe = 1'b0;
   logic       pulse_q = 1'b0;
   logic       hv_q = 1'b0;

   typedef struct {
      int pass; int fail; int faddr; int pulses; int fetches; int creads; string tag;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   otp_burn_seq #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CLKS(PC), .MAX_TRIES(MT)) u_otp_burn_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .last_addr_i(last_addr),
      .img_req_o(img_req), .img_addr_o(img_addr), .img_data_i(img_data), .img_vld_i(img_vld),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
      .mem_regsel_o(mem_regsel), .mem_rw_o(mem_rw), .mem_rd_o(mem_rd),
      .mem_pulse_o(mem_pulse), .hv_en_o(hv), .busy_o(busy), .pass_o(pass),
      .fail_o(fail), .fail_addr_o(fail_addr)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // image source: answers a request two clocks later
   always @(posedge clk) begin
      if (img_req && !img_vld && !img_lat) begin
         img_lat <= 1'b1;
         img_vld <= 1'b0;
      end else if (img_lat) begin
         img_lat  <= 1'b0;
         img_vld  <= 1'b1;
         img_data <= img[img_addr];
      end else begin
         img_vld <= 1'b0;
      end
   end

   // memory stub: a cell takes the programmed zeros after need[] pulses
   always @(posedge clk) begin
      pulse_q <= mem_pulse;
      hv_q    <= hv;
      if (wipe) begin
         for (int i = 0; i < 64; i++) begin
            mem[i]  <= 8'hFF;
            hits[i] <= 0;
         end
      end else begin
         if (mem_rd) mem_rdata <= mem[mem_addr];
         if (mem_pulse && !pulse_q) begin
            hits[mem_addr] <= hits[mem_addr] + 1;
            if (hits[mem_addr] + 1 >= need[mem_addr])
               mem[mem_addr] <= mem[mem_addr] & mem_wdata;
         end
         if (hv_q && !hv && busy && bad_addr >= 0)
            mem[bad_addr[5:0]] <= mem[bad_addr[5:0]] ^ 8'h01;
      end
   end

   // monitor: counts activity of each run and scores it at its end
   logic busy_prev = 1'b0;
   logic req_prev  = 1'b0;
   int pulses, pcycles, fetches, creads, vreads, viol;
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy && !busy_prev) begin
            pulses = 0; pcycles = 0; fetches = 0; creads = 0; vreads = 0; viol = 0;
         end
         if (busy) begin
            if (mem_pulse && !pulse_q) pulses++;
            if (mem_pulse) begin
               pcycles++;
               if (mem_rw || !hv || mem_regsel) viol++;
            end
            if (img_req && !req_prev) fetches++;
            if (mem_rd && hv) vreads++;
            if (mem_rd && !hv) creads++;
         end
         if (!busy && busy_prev) begin
            if (q.size() == 0) begin
               chk("R8", "unexpected run end", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk("R7", {e.tag, " pass"}, int'(pass), e.pass);
               chk("R6", {e.tag, " fail"}, int'(fail), e.fail);
               if (e.fail != 0) chk("R6", {e.tag, " fail address"}, int'(fail_addr), e.faddr);
               chk("R5", {e.tag, " pulses"}, pulses, e.pulses);
               chk("R3", {e.tag, " pulse cycles"}, pcycles, e.pulses * PC);
               chk("R3", {e.tag, " pulse mode"}, viol, 0);
               chk("R4", {e.tag, " verify reads"}, vreads, e.pulses);
               chk("R7", {e.tag, " compare reads"}, creads, e.creads);
               chk("R9", {e.tag, " fetches"}, fetches, e.fetches);
            end
         end
         busy_prev <= busy;
         req_prev  <= img_req;
      end
   end

   task automatic prep(int L, int nd, logic ff_img, int bad);
      for (int i = 0; i < 64; i++) begin
         need[i] = nd;
         img[i]  = ff_img ? 8'hFF : 8'((i * 29 + 3) & 8'h7F);
      end
      bad_addr = bad;
      @(negedge clk) wipe = 1'b1;
      @(negedge clk) wipe = 1'b0;
      last_addr = AW'(L);
   endtask

   task automatic run(string tag, int L, int ep, int fa, int np, int nf, int nc, int mid);
      exp_t e;
      e.pass = ep; e.fail = 1 - ep; e.faddr = fa; e.pulses = np;
      e.fetches = nf; e.creads = nc; e.tag = tag;
      q.push_back(e);
      @(negedge clk) start = 1'b1;
      last_addr = AW'(L);
      @(negedge clk) start = 1'b0;
      chk("R2", {tag, " busy after start"}, int'(busy), 1);
      chk("R2", {tag, " flags cleared"}, int'(pass || fail), 0);
      if (mid > 0) begin
         repeat (mid) @(negedge clk);
         start = 1'b1;
         last_addr = '0;
         @(negedge clk) start = 1'b0;
      end
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      chk("R8", {tag, " sticky pass"}, int'(pass), ep);
      chk("R8", {tag, " sticky fail"}, int'(fail), 1 - ep);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "busy in reset", int'(busy), 0);
      chk("R1", "flags in reset", int'(pass || fail), 0);
      chk("R1", "hv in reset", int'(hv || mem_pulse), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "idle after reset", int'(busy || hv || pass || fail), 0);

      // R7 plain pass, one pulse per byte
      prep(7, 1, 1'b0, -1);
      run("T2", 7, 1, 0, 8, 16, 8, 0);

      // R5 R6 mixed needs, byte 4 needs exactly MAX_TRIES pulses
      prep(5, 1, 1'b0, -1);
      need[1] = 3; need[2] = 2; need[4] = MT;
      run("T3", 5, 1, 0, 18, 12, 6, 0);

      // R6 byte 3 never takes within MAX_TRIES
      prep(7, 1, 1'b0, -1);
      need[3] = MT + 1;
      run("T4", 7, 0, 3, 13, 4, 0, 0);

      // R7 byte 4 disturbed after programming, caught in compare pass
      prep(6, 2, 1'b0, 4);
      run("T5", 6, 0, 4, 14, 12, 5, 0);

      // R2 start while busy ignored
      prep(9, 2, 1'b0, -1);
      run("T6", 9, 1, 0, 20, 20, 10, 15);

      // single byte run
      prep(0, 1, 1'b0, -1);
      run("T7", 0, 1, 0, 1, 2, 1, 0);

      // erased-value image: first verify matches whatever the cell needs
      prep(3, 5, 1'b1, -1);
      run("T8", 3, 1, 0, 4, 8, 4, 0);

      chk("R8", "scoreboard drained", q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule